// File: doc/BRIEF.md
# Instruction Cache Tag Array Access Port

This block gives a 32-bit bus master direct access to the tag and valid bits of a two-way set-associative instruction cache with 256 sets. Each access is a single longword strobe. The address word picks the way, the set and whether the access is associative. The data word carries a tag and a valid bit. A read returns the stored tag and valid bit of one line. A direct write stores a new tag and valid bit into one line.

An associative write is used to invalidate a line when software knows only its address. The way bit is ignored. The supplied tag is compared against every way of the addressed set, and only a way that is valid and whose tag matches takes the supplied valid bit. Every other outcome is a silent no-op.

When address translation is enabled, an associative write first sends its 22-bit virtual tag out on a request port. It then waits for a hit, miss or multiple-hit answer before it compares. A miss is a no-op. A multiple hit is also a no-op, and it raises a one-cycle fault output.

Top module: `ictag_port`

## Requirements
- R1: After reset every valid bit in both ways is 0, `rsp_ready`, `fault` and `xlat_req` are low, and a read of any line returns bit 0 equal to 0.
- R2: An access is carried out only when address bits [31:24] equal 0xF0 and bits [1:0] are 00. Any other access still completes with `rsp_ready`, returns zero read data and changes no line.
- R3: Address bit 13 selects the way and bits [12:5] select the set. A read returns the stored tag in data bits [28:10] and the valid bit in bit 0, with bits [31:29] and [9:1] always zero.
- R4: A direct write (bit 3 = 0) stores data bits [28:10] as the tag and data bit 0 as the valid bit of the addressed line, and ignores data bits [31:29].
- R5: Address bit 3 has no effect on a read.
- R6: An associative write (write with bit 3 = 1) with translation off ignores the way bit. It compares data bits [28:10] with the tag of each way at the addressed set, and writes data bit 0 into the valid bit of each way that matches and is valid. Stored tags are left unchanged.
- R7: An associative write whose tag matches no valid way changes no line and does not raise `fault`.
- R8: When both ways of the set hold the matching tag and are valid, an associative write updates both.
- R9: With `xlat_en` high, an associative write raises `xlat_req` with `xlat_vtag` equal to data bits [31:10], held steady until a cycle with `xlat_rsp` high. On a hit the comparison of R6 uses `xlat_ptag` in place of the data tag.
- R10: A translation response with `xlat_hit` low and `xlat_multi` low changes no line and does not raise `fault`.
- R11: A translation response with `xlat_multi` high changes no line and raises `fault` for exactly the one cycle in which `rsp_ready` is high.
- R12: `rsp_ready` pulses for one cycle, in the cycle after the request strobe for any access that does not wait for translation, and in the cycle after the translation response otherwise. `req_valid` is a one-cycle strobe, and a new one may follow only after `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address word (region, way, set, association flag) |
| req_wdata | input | 32 | Write data word (tag, valid bit) |
| xlat_en | input | 1 | Translate associative-write tags before comparing |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data word, valid with `rsp_ready` |
| fault | output | 1 | Multiple-hit translation fault pulse |
| xlat_req | output | 1 | Translation request, held until the response |
| xlat_vtag | output | 22 | Virtual tag to translate |
| xlat_rsp | input | 1 | Translation response strobe |
| xlat_hit | input | 1 | Translation found a single mapping |
| xlat_multi | input | 1 | Translation found several mappings |
| xlat_ptag | input | 19 | Translated physical tag |

## Verification
Associative writes are tried against several set contents. In one set only the way that the way bit does not name matches, which separates a compare of every way from a compare of the selected way. A matching way whose valid bit is already clear is tried, as are a fully mismatched tag and a set with both ways equal. These show that only valid matching ways are updated and that tags survive. Direct writes carry nonzero data bits [31:29], and reads are repeated with the association flag set, so that ignored fields show up at the read port. Translated writes are answered with a hit, a miss, a multiple hit and a hit whose physical tag differs from the data tag. Each answer comes after a delay, so the hold of the request and the choice of compare tag are both exposed.

// File: rtl/ictag_pkg.sv
package ictag_pkg;
    // Address word layout; these positions are decoded by the bus side.
    localparam logic [7:0] REGION_ID = 8'hF0;
    localparam int REGION_LSB = 24;
    localparam int WAY_BIT    = 13;
    localparam int SET_LSB    = 5;
    localparam int ASSOC_BIT  = 3;
    // Data word layout.
    localparam int TAG_LSB    = 10;
    localparam int VTAG_W     = 22;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XLAT = 1'b1
    } ictag_state_e;
endpackage

// File: rtl/ictag_decode.sv
module ictag_decode
    import ictag_pkg::*;
#(
    parameter int SET_W = 8,
    parameter int WAY_W = 1,
    parameter int TAG_W = 19
) (
    input  logic [31:0]       addr,
    input  logic [31:0]       wdata,
    output logic              sel_ok,
    output logic [WAY_W-1:0]  sel_way,
    output logic [SET_W-1:0]  sel_set,
    output logic              sel_assoc,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [VTAG_W-1:0] wr_vtag,
    output logic              wr_valid
);
    logic unused_bits;

    always_comb begin
        sel_ok    = (addr[31:REGION_LSB] == REGION_ID) && (addr[1:0] == 2'b00);
        sel_way   = addr[WAY_BIT +: WAY_W];
        sel_set   = addr[SET_LSB +: SET_W];
        sel_assoc = addr[ASSOC_BIT];
        // Stored tag omits the upper bits of the data tag field.
        wr_tag    = wdata[TAG_LSB +: TAG_W];
        wr_vtag   = wdata[TAG_LSB +: VTAG_W];
        wr_valid  = wdata[0];
    end

    assign unused_bits = ^{addr, wdata};
endmodule

// File: rtl/ictag_array.sv
module ictag_array #(
    parameter int WAYS    = 2,
    parameter int SETS    = 256,
    parameter int TAG_W   = 19,
    localparam int SET_W  = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]             rd_valid,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [WAYS-1:0]             tag_we,
    input  logic [WAYS-1:0]             valid_we,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        wr_valid
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  valid_q;

        // Tags carry no reset; a line is meaningless while its valid bit is 0.
        always_ff @(posedge clk) begin
            if (tag_we[w]) begin
                tag_mem[wr_set] <= wr_tag;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
            end else if (valid_we[w]) begin
                valid_q[wr_set] <= wr_valid;
            end
        end

        assign rd_tag[w]   = tag_mem[rd_set];
        assign rd_valid[w] = valid_q[rd_set];
    end
endmodule

// File: rtl/ictag_match.sv
module ictag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 19
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           cmp_tag,
    output logic [WAYS-1:0]            hit_vec
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == cmp_tag);
    end
endmodule

// File: rtl/ictag_port.sv
module ictag_port
    import ictag_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int SETS  = 256,
    parameter int TAG_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              xlat_en,
    output logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    output logic              fault,
    output logic              xlat_req,
    output logic [VTAG_W-1:0] xlat_vtag,
    input  logic              xlat_rsp,
    input  logic              xlat_hit,
    input  logic              xlat_multi,
    input  logic [TAG_W-1:0]  xlat_ptag
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int PAD_W = 32 - TAG_LSB - TAG_W;

    typedef struct packed {
        ictag_state_e       st;
        logic [SET_W-1:0]   set;
        logic               vbit;
        logic [VTAG_W-1:0]  vtag;
        logic               ready;
        logic               fault;
        logic [31:0]        rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              dec_ok;
    logic [WAY_W-1:0]  dec_way;
    logic [SET_W-1:0]  dec_set;
    logic              dec_assoc;
    logic [TAG_W-1:0]  dec_tag;
    logic [VTAG_W-1:0] dec_vtag;
    logic              dec_valid;

    logic [SET_W-1:0]            rd_set;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [SET_W-1:0]            wr_set;
    logic [WAYS-1:0]             tag_we;
    logic [WAYS-1:0]             valid_we;
    logic                        wr_valid;
    logic [TAG_W-1:0]            cmp_tag;
    logic [WAYS-1:0]             hit_vec;

    ictag_decode #(
        .SET_W (SET_W),
        .WAY_W (WAY_W),
        .TAG_W (TAG_W)
    ) u_decode (
        .addr      (req_addr),
        .wdata     (req_wdata),
        .sel_ok    (dec_ok),
        .sel_way   (dec_way),
        .sel_set   (dec_set),
        .sel_assoc (dec_assoc),
        .wr_tag    (dec_tag),
        .wr_vtag   (dec_vtag),
        .wr_valid  (dec_valid)
    );

    ictag_array #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (rd_set),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .wr_set   (wr_set),
        .tag_we   (tag_we),
        .valid_we (valid_we),
        .wr_tag   (dec_tag),
        .wr_valid (wr_valid)
    );

    ictag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .way_tag   (rd_tag),
        .way_valid (rd_valid),
        .cmp_tag   (cmp_tag),
        .hit_vec   (hit_vec)
    );

    // While waiting on translation the latched set and physical tag drive the compare.
    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.ready = 1'b0;
        ctl_d.fault = 1'b0;
        tag_we   = '0;
        valid_we = '0;
        wr_set   = dec_set;
        wr_valid = dec_valid;
        rd_set   = (ctl_q.st == ST_IDLE) ? dec_set : ctl_q.set;
        cmp_tag  = (ctl_q.st == ST_IDLE) ? dec_tag : xlat_ptag;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.rdata = '0;
                    if (!dec_ok) begin
                        ctl_d.ready = 1'b1;
                    end else if (!req_write) begin
                        ctl_d.rdata = {{PAD_W{1'b0}}, rd_tag[dec_way],
                                       {(TAG_LSB-1){1'b0}}, rd_valid[dec_way]};
                        ctl_d.ready = 1'b1;
                    end else if (!dec_assoc) begin
                        tag_we[dec_way]   = 1'b1;
                        valid_we[dec_way] = 1'b1;
                        ctl_d.ready = 1'b1;
                    end else if (xlat_en) begin
                        ctl_d.st   = ST_XLAT;
                        ctl_d.set  = dec_set;
                        ctl_d.vbit = dec_valid;
                        ctl_d.vtag = dec_vtag;
                    end else begin
                        valid_we    = hit_vec;
                        ctl_d.ready = 1'b1;
                    end
                end
            end
            ST_XLAT: begin
                wr_set   = ctl_q.set;
                wr_valid = ctl_q.vbit;
                if (xlat_rsp) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.ready = 1'b1;
                    if (xlat_multi) begin
                        ctl_d.fault = 1'b1;
                    end else if (xlat_hit) begin
                        valid_we = hit_vec;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_ready = ctl_q.ready;
    assign rsp_rdata = ctl_q.rdata;
    assign fault     = ctl_q.fault;
    assign xlat_req  = (ctl_q.st == ST_XLAT);
    assign xlat_vtag = ctl_q.vtag;
endmodule

// File: rtl/ictag_port_chk.sv
module ictag_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        xlat_en,
    input logic        rsp_ready,
    input logic [31:0] rsp_rdata,
    input logic        fault,
    input logic        xlat_req,
    input logic [21:0] xlat_vtag,
    input logic        xlat_rsp,
    input logic        xlat_multi
);
    logic waits_xlat;
    assign waits_xlat = req_write && req_addr[3] && xlat_en &&
                        (req_addr[31:24] == 8'hF0) && (req_addr[1:0] == 2'b00);

    // R12
    direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xlat_req && !waits_xlat |=> rsp_ready);

    // R9
    xlat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xlat_req) |-> rsp_ready);

    // R9
    xlat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req && !xlat_rsp |=> xlat_req && $stable(xlat_vtag));

    // R3
    rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (rsp_rdata[31:29] == 3'b000) && (rsp_rdata[9:1] == 9'd0));

    // R11
    fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> rsp_ready && $past(xlat_req && xlat_rsp && xlat_multi));

    // R11
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);
endmodule

bind ictag_port ictag_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .xlat_en    (xlat_en),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .fault      (fault),
    .xlat_req   (xlat_req),
    .xlat_vtag  (xlat_vtag),
    .xlat_rsp   (xlat_rsp),
    .xlat_multi (xlat_multi)
);

// File: tb/ictag_port_test.sv
`timescale 1ns/1ps
module ictag_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        xlat_en = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic        fault;
    logic        xlat_req;
    logic [21:0] xlat_vtag;
    logic        xlat_rsp = 1'b0;
    logic        xlat_hit = 1'b0;
    logic        xlat_multi = 1'b0;
    logic [18:0] xlat_ptag = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ictag_port uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .xlat_en(xlat_en),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .fault(fault),
        .xlat_req(xlat_req), .xlat_vtag(xlat_vtag), .xlat_rsp(xlat_rsp),
        .xlat_hit(xlat_hit), .xlat_multi(xlat_multi), .xlat_ptag(xlat_ptag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk_addr(input logic way, input int set, input logic assoc);
        return {8'hF0, 10'd0, way, set[7:0], 1'b0, assoc, 3'b000};
    endfunction

    function automatic logic [31:0] mk_data(input logic [2:0] hi, input logic [18:0] tag, input logic v);
        return {hi, tag, 9'd0, v};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Strobe one access and check the one-cycle completion (R12).
    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_ready === 1'b1, "R12 ready after strobe", {31'd0, rsp_ready}, 32'd1);
        rd = rsp_rdata;
        @(negedge clk);
        check(rsp_ready === 1'b0, "R12 ready single pulse", {31'd0, rsp_ready}, 32'd0);
    endtask

    task automatic expect_read(input logic way, input int set, input logic [31:0] exp, input string req);
        logic [31:0] rd;
        access(1'b0, mk_addr(way, set, 1'b0), '0, rd);
        check(rd === exp, req, rd, exp);
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        check(rsp_ready === 1'b0 && fault === 1'b0 && xlat_req === 1'b0, "R1 idle outputs",
              {29'd0, rsp_ready, fault, xlat_req}, 32'd0);
        access(1'b0, mk_addr(1'b0, 0, 1'b0), '0, rd);
        check(rd[0] === 1'b0, "R1 way0 set0 invalid", rd, 32'd0);
        access(1'b0, mk_addr(1'b1, 255, 1'b0), '0, rd);
        check(rd[0] === 1'b0, "R1 way1 set255 invalid", rd, 32'd0);
    endtask

    task automatic t_direct;
        logic [31:0] rd;
        access(1'b1, mk_addr(1'b0, 5, 1'b0), mk_data(3'b111, 19'h2A5A5, 1'b1), rd);
        access(1'b1, mk_addr(1'b1, 5, 1'b0), mk_data(3'b101, 19'h13C3C, 1'b1), rd);
        access(1'b1, mk_addr(1'b1, 6, 1'b0), mk_data(3'b000, 19'h7FFFF, 1'b0), rd);
        expect_read(1'b0, 5, mk_data(3'b000, 19'h2A5A5, 1'b1), "R3 R4 way0 set5");
        expect_read(1'b1, 5, mk_data(3'b000, 19'h13C3C, 1'b1), "R3 R4 way1 set5");
        expect_read(1'b1, 6, mk_data(3'b000, 19'h7FFFF, 1'b0), "R3 way1 set6 tag no valid");
        access(1'b0, mk_addr(1'b1, 5, 1'b1), '0, rd);
        check(rd === mk_data(3'b000, 19'h13C3C, 1'b1), "R5 read with assoc flag", rd,
              mk_data(3'b000, 19'h13C3C, 1'b1));
    endtask

    task automatic t_decode;
        logic [31:0] rd;
        logic [31:0] a;
        a = mk_addr(1'b0, 5, 1'b0);
        a[31:24] = 8'hF1;
        access(1'b1, a, mk_data(3'b000, 19'h00001, 1'b0), rd);
        a = mk_addr(1'b0, 5, 1'b0) | 32'h1;
        access(1'b1, a, mk_data(3'b000, 19'h00002, 1'b0), rd);
        expect_read(1'b0, 5, mk_data(3'b000, 19'h2A5A5, 1'b1), "R2 rejected writes no change");
        a = mk_addr(1'b0, 5, 1'b0);
        a[31:24] = 8'hE0;
        access(1'b0, a, '0, rd);
        check(rd === 32'd0, "R2 rejected read data", rd, 32'd0);
    endtask

    task automatic t_assoc;
        logic [31:0] rd;
        access(1'b1, mk_addr(1'b0, 7, 1'b0), mk_data(3'b000, 19'h11111, 1'b1), rd);
        access(1'b1, mk_addr(1'b1, 7, 1'b0), mk_data(3'b000, 19'h22222, 1'b1), rd);
        // Way bit names way1, but only way0 matches.
        access(1'b1, mk_addr(1'b1, 7, 1'b1), mk_data(3'b110, 19'h11111, 1'b0), rd);
        check(fault === 1'b0, "R7 no fault on assoc", {31'd0, fault}, 32'd0);
        expect_read(1'b0, 7, mk_data(3'b000, 19'h11111, 1'b0), "R6 way0 cleared tag kept");
        expect_read(1'b1, 7, mk_data(3'b000, 19'h22222, 1'b1), "R6 way1 untouched");
        // Matching tag on an invalid way must not be revived.
        access(1'b1, mk_addr(1'b0, 7, 1'b1), mk_data(3'b000, 19'h11111, 1'b1), rd);
        expect_read(1'b0, 7, mk_data(3'b000, 19'h11111, 1'b0), "R7 invalid way stays invalid");
        access(1'b1, mk_addr(1'b1, 7, 1'b1), mk_data(3'b000, 19'h33333, 1'b0), rd);
        expect_read(1'b1, 7, mk_data(3'b000, 19'h22222, 1'b1), "R7 mismatch no change");
        access(1'b1, mk_addr(1'b0, 9, 1'b0), mk_data(3'b000, 19'h05555, 1'b1), rd);
        access(1'b1, mk_addr(1'b1, 9, 1'b0), mk_data(3'b000, 19'h05555, 1'b1), rd);
        access(1'b1, mk_addr(1'b0, 9, 1'b1), mk_data(3'b000, 19'h05555, 1'b0), rd);
        expect_read(1'b0, 9, mk_data(3'b000, 19'h05555, 1'b0), "R8 both ways way0");
        expect_read(1'b1, 9, mk_data(3'b000, 19'h05555, 1'b0), "R8 both ways way1");
    endtask

    // Associative write through translation; response after a two-cycle wait.
    task automatic xl(input logic [31:0] d, input int set, input logic hit, input logic multi,
                      input logic [18:0] ptag, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = mk_addr(1'b0, set, 1'b1); req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(xlat_req === 1'b1 && rsp_ready === 1'b0, {"R9 request raised ", req},
              {30'd0, xlat_req, rsp_ready}, 32'd2);
        check(xlat_vtag === d[31:10], {"R9 vtag ", req}, {10'd0, xlat_vtag}, {10'd0, d[31:10]});
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(xlat_req === 1'b1 && rsp_ready === 1'b0, {"R9 request held ", req},
                  {30'd0, xlat_req, rsp_ready}, 32'd2);
        end
        xlat_rsp = 1'b1; xlat_hit = hit; xlat_multi = multi; xlat_ptag = ptag;
        @(posedge clk);
        @(negedge clk);
        xlat_rsp = 1'b0; xlat_hit = 1'b0; xlat_multi = 1'b0;
        check(rsp_ready === 1'b1 && xlat_req === 1'b0, {"R12 ready after response ", req},
              {30'd0, rsp_ready, xlat_req}, 32'd2);
        check(fault === multi, {"R11 fault level ", req}, {31'd0, fault}, {31'd0, multi});
        @(negedge clk);
        check(fault === 1'b0 && rsp_ready === 1'b0, {"R11 fault single pulse ", req},
              {30'd0, fault, rsp_ready}, 32'd0);
    endtask

    task automatic t_xlat;
        logic [31:0] rd;
        xlat_en = 1'b1;
        access(1'b1, mk_addr(1'b1, 11, 1'b0), mk_data(3'b000, 19'h4ABCD, 1'b1), rd);
        xl(mk_data(3'b011, 19'h00F0F, 1'b0), 11, 1'b0, 1'b0, 19'h4ABCD, "miss");
        expect_read(1'b1, 11, mk_data(3'b000, 19'h4ABCD, 1'b1), "R10 miss no change");
        xl(mk_data(3'b011, 19'h00F0F, 1'b0), 11, 1'b1, 1'b1, 19'h4ABCD, "multi");
        expect_read(1'b1, 11, mk_data(3'b000, 19'h4ABCD, 1'b1), "R11 multi no change");
        xl(mk_data(3'b000, 19'h4ABCD, 1'b0), 11, 1'b1, 1'b0, 19'h00F0F, "hit other ptag");
        expect_read(1'b1, 11, mk_data(3'b000, 19'h4ABCD, 1'b1), "R9 compare uses ptag");
        xl(mk_data(3'b011, 19'h00F0F, 1'b0), 11, 1'b1, 1'b0, 19'h4ABCD, "hit");
        expect_read(1'b1, 11, mk_data(3'b000, 19'h4ABCD, 1'b0), "R9 hit clears way1");
        xlat_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_decode();
        t_assoc();
        t_xlat();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule